// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block moves one 8-bit PCM byte per frame in each direction over a serial backplane bus. A bit clock paces the bus. Transmit and receive each have their own frame sync and their own position counter, so the two frames may be skewed by any number of bit clocks. Transmit bits change on rising bit-clock edges and receive bits are sampled on falling edges, most significant bit first. Next to the transmit data, the block drives an output enable that stands for the tri-state pin. It also drives an active-low enable for a backplane line driver.

Two timing modes are supported. In the non-delayed mode the slot opens on the bit-clock rising edge at which frame sync is first seen high, and the programmed slot number has no effect. In the delayed mode the falling edge that first samples frame sync high marks the frame. Bit 0 of slot 0 then starts on the next rising edge, and a per-direction counter places the programmed slot. Each direction takes a configuration word: a slot number plus an enable bit. A power input gates all traffic. After power is applied, transmit stays in high impedance until the second transmit frame sync. A loopback mode returns the last received byte in the transmit slot.

The bit clock, frame syncs and receive data are sampled by `clk_i`. Each bit-clock level must hold for at least two `clk_i` cycles.

Top module: `pcm_tsi`

## Requirements
- R1: In its transmit slot the block drives 8 bits MSB first on `dx_o`, with `dx_oe_o` high for exactly those 8 bit times. `dx_o` changes only after a bit-clock rising edge.
- R2: In its receive slot `dr_i` is sampled on 8 bit-clock falling edges, MSB first. One clock after the 8th falling edge the byte appears on `rx_byte_o` with `rx_valid_o` high for one cycle. `rx_byte_o` holds its value otherwise.
- R3: With `delayed_i`=0 a slot starts on the bit-clock rising edge at which its frame sync is first seen high, and the slot number in the configuration word is ignored.
- R4: With `delayed_i`=1 a falling edge that samples frame sync high, after sampling it low, marks the frame. Slot n (0 to NUM_SLOTS-1) starts 8n+1 rising edges later, counting the first rising edge after the mark as rising edge 1.
- R5: The transmit and receive frames are counted independently, so a skew between `fsx_i` and `fsr_i` moves only the slot of that direction.
- R6: `tsx_no` is low from the first rising edge of a driven transmit slot until the falling edge inside its 8th bit, and high at all other times.
- R7: While `pwr_up_i`=0 `dx_oe_o` stays 0, `tsx_no` stays 1 and no byte is received.
- R8: After `pwr_up_i` rises, the first transmit frame is not driven. Transmit starts with the frame marked by the second `fsx_i` pulse.
- R9: With `loopback_i`=1 the transmit slot sends the value of `rx_byte_o` held at slot start instead of `tx_byte_i`.
- R10: A configuration word has its enable in bit SLOT_W and the slot number in bits SLOT_W-1:0. With the enable at 0 that direction neither drives nor receives.
- R11: After reset `dx_oe_o`=0, `tsx_no`=1, `rx_valid_o`=0 and `rx_byte_o`=0.
- R12: The transmit byte is taken from `tx_byte_i` at the rising edge that opens the slot. Later changes during the slot do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bus bit clock, sampled by clk_i |
| fsx_i | input | 1 | Transmit frame sync |
| fsr_i | input | 1 | Receive frame sync |
| dr_i | input | 1 | Serial receive data |
| delayed_i | input | 1 | 1: delayed timing with slot counters; 0: slot opens at frame sync |
| loopback_i | input | 1 | Send the held receive byte in the transmit slot |
| pwr_up_i | input | 1 | Powered-up state |
| tx_cfg_i | input | SLOT_W+1 | Transmit enable (MSB) and slot number |
| rx_cfg_i | input | SLOT_W+1 | Receive enable (MSB) and slot number |
| tx_byte_i | input | 8 | Transmit holding register |
| rx_byte_o | output | 8 | Receive holding register |
| rx_valid_o | output | 1 | One-cycle strobe on a new received byte |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Transmit drive enable; 0 means high impedance |
| tsx_no | output | 1 | Line-driver enable, active low |

## Verification
The bench builds the block with NUM_SLOTS=8 (SLOT_W=3) and a bit clock of eight system clocks. At that size a frame is only 68 bit times long, so the last slot, the end of the counter range and several whole frames per scenario fit in a short run. The receive frame lags the transmit frame by three bit times. With that skew and the last slot selected, the final receive bit lands exactly on the last bit of the bench frame, which tests the independence of the two counters at their limit. Every frame loads a new transmit byte and corrupts it two bits into the slot, so the latch point is checked in every scenario.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
  localparam int PCM_W = 8;
  localparam int BIT_W = $clog2(PCM_W);

  typedef enum int {
    DIR_TX = 0,
    DIR_RX = 1
  } dir_e;

  localparam int NUM_DIR = 2;
endpackage

// File: rtl/pcm_bclk_edge.sv
module pcm_bclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic bclk_lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  assign bclk_lvl_o = bclk_q;
  assign rise_o     = bclk_i & ~bclk_q;
  assign fall_o     = ~bclk_i & bclk_q;
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_tsi_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              fs_i,
  input  logic              delayed_i,
  input  logic              enable_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              active_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              slot_start_o,
  output logic              frame_start_o
);
  localparam int POS_W = SLOT_W + BIT_W;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_SLOTS * PCM_W - 1);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic              run_q, run_d;
  logic              fs_at_rise_q, fs_at_fall_q, armed_q;
  logic              start;
  logic [SLOT_W-1:0] target;

  assign target = delayed_i ? slot_i : '0;
  assign start  = delayed_i ? armed_q : (fs_i & ~fs_at_rise_q);

  always_comb begin
    pos_d = pos_q;
    run_d = run_q;
    if (rise_i) begin
      if (start) begin
        pos_d = '0;
        run_d = 1'b1;
      end else if (run_q) begin
        if (pos_q == LAST_POS) run_d = 1'b0;
        else                   pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q        <= '0;
      run_q        <= 1'b0;
      fs_at_rise_q <= 1'b0;
      fs_at_fall_q <= 1'b0;
      armed_q      <= 1'b0;
    end else begin
      pos_q <= pos_d;
      run_q <= run_d;
      if (rise_i) begin
        fs_at_rise_q <= fs_i;
        armed_q      <= 1'b0;
      end else if (fall_i) begin
        fs_at_fall_q <= fs_i;
        // frame mark: first falling edge that sees sync high
        if (fs_i && !fs_at_fall_q) armed_q <= 1'b1;
      end
    end
  end

  assign active_o      = run_q & enable_i & (pos_q[POS_W-1:BIT_W] == target);
  assign bit_o         = pos_q[BIT_W-1:0];
  assign slot_start_o  = rise_i & run_d & enable_i &
                         (pos_d[POS_W-1:BIT_W] == target) & (pos_d[BIT_W-1:0] == '0);
  assign frame_start_o = rise_i & start;
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_tsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_up_i,
  input  logic             frame_start_i,
  input  logic             slot_start_i,
  input  logic             active_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             bclk_lvl_i,
  input  logic [PCM_W-1:0] src_i,
  output logic             dx_o,
  output logic             dx_oe_o,
  output logic             tsx_no
);
  localparam logic [1:0]       GATE_OPEN = 2'd2;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(PCM_W - 1);

  logic [PCM_W-1:0] sh_q;
  logic [1:0]       sync_cnt_q;
  logic             drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      sync_cnt_q <= '0;
    end else begin
      if (!pwr_up_i)                                    sync_cnt_q <= '0;
      else if (frame_start_i && sync_cnt_q != GATE_OPEN) sync_cnt_q <= sync_cnt_q + 1'b1;
      if (slot_start_i) sh_q <= src_i;
    end
  end

  assign drive   = active_i & pwr_up_i & (sync_cnt_q == GATE_OPEN);
  assign dx_oe_o = drive;
  assign dx_o    = drive & sh_q[LAST_BIT - bit_i];
  // released during the low half of the last bit
  assign tsx_no  = ~(drive & ~((bit_i == LAST_BIT) & ~bclk_lvl_i));
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_tsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             active_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             dr_i,
  output logic [PCM_W-1:0] rx_byte_o,
  output logic             rx_valid_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PCM_W - 1);

  logic [PCM_W-1:0] sh_q;
  logic             take;

  assign take = fall_i & active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= take & (bit_i == LAST_BIT);
      if (take) begin
        sh_q <= {sh_q[PCM_W-2:0], dr_i};
        if (bit_i == LAST_BIT) rx_byte_o <= {sh_q[PCM_W-2:0], dr_i};
      end
    end
  end
endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
  import pcm_tsi_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsx_i,
  input  logic              fsr_i,
  input  logic              dr_i,
  input  logic              delayed_i,
  input  logic              loopback_i,
  input  logic              pwr_up_i,
  input  logic [SLOT_W:0]   tx_cfg_i,
  input  logic [SLOT_W:0]   rx_cfg_i,
  input  logic [PCM_W-1:0]  tx_byte_i,
  output logic [PCM_W-1:0]  rx_byte_o,
  output logic              rx_valid_o,
  output logic              dx_o,
  output logic              dx_oe_o,
  output logic              tsx_no
);
  logic bclk_lvl, rise, fall;

  logic [SLOT_W:0]  cfg_v       [NUM_DIR];
  logic             fs_v        [NUM_DIR];
  logic             active_v    [NUM_DIR];
  logic [BIT_W-1:0] bit_v       [NUM_DIR];
  logic             slot_start_v[NUM_DIR];
  logic             frame_v     [NUM_DIR];

  assign cfg_v[DIR_TX] = tx_cfg_i;
  assign cfg_v[DIR_RX] = rx_cfg_i;
  assign fs_v[DIR_TX]  = fsx_i;
  assign fs_v[DIR_RX]  = fsr_i;

  pcm_bclk_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .bclk_lvl_o (bclk_lvl),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    pcm_slot_timer #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
    ) u_timer (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .rise_i        (rise),
      .fall_i        (fall),
      .fs_i          (fs_v[d]),
      .delayed_i     (delayed_i),
      .enable_i      (cfg_v[d][SLOT_W] & pwr_up_i),
      .slot_i        (cfg_v[d][SLOT_W-1:0]),
      .active_o      (active_v[d]),
      .bit_o         (bit_v[d]),
      .slot_start_o  (slot_start_v[d]),
      .frame_start_o (frame_v[d])
    );
  end

  pcm_rx_path u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .active_i   (active_v[DIR_RX]),
    .bit_i      (bit_v[DIR_RX]),
    .dr_i       (dr_i),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o)
  );

  pcm_tx_path u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_up_i      (pwr_up_i),
    .frame_start_i (frame_v[DIR_TX]),
    .slot_start_i  (slot_start_v[DIR_TX]),
    .active_i      (active_v[DIR_TX]),
    .bit_i         (bit_v[DIR_TX]),
    .bclk_lvl_i    (bclk_lvl),
    .src_i         (loopback_i ? rx_byte_o : tx_byte_i),
    .dx_o          (dx_o),
    .dx_oe_o       (dx_oe_o),
    .tsx_no        (tsx_no)
  );

  // frame/slot signals of the receive timer not otherwise needed
  logic unused_rx;
  assign unused_rx = slot_start_v[DIR_RX] ^ frame_v[DIR_RX];
endmodule

// File: rtl/pcm_tsi_sva.sv
module pcm_tsi_sva #(
  parameter int SLOT_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bclk_i,
  input logic            pwr_up_i,
  input logic [SLOT_W:0] tx_cfg_i,
  input logic [7:0]      rx_byte_o,
  input logic            rx_valid_o,
  input logic            dx_o,
  input logic            dx_oe_o,
  input logic            tsx_no
);
  AST_DX_CHANGES_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dx_oe_o && $past(dx_oe_o) && !($past(bclk_i) && !$past(bclk_i, 2)) |-> $stable(dx_o)); // R1

  AST_RX_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R2

  AST_RX_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_byte_o)); // R2

  AST_TSX_RELEASE_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsx_no) && dx_oe_o |-> !bclk_i); // R6

  AST_PDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |-> !dx_oe_o && tsx_no && !rx_valid_o); // R7

  AST_PWRUP_NOT_AT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_up_i) |=> !dx_oe_o); // R8

  AST_TX_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_cfg_i[SLOT_W] |-> !dx_oe_o && tsx_no); // R10
endmodule

bind pcm_tsi pcm_tsi_sva #(.SLOT_W(SLOT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bclk_i     (bclk_i),
  .pwr_up_i   (pwr_up_i),
  .tx_cfg_i   (tx_cfg_i),
  .rx_byte_o  (rx_byte_o),
  .rx_valid_o (rx_valid_o),
  .dx_o       (dx_o),
  .dx_oe_o    (dx_oe_o),
  .tsx_no     (tsx_no)
);

// File: tb/pcm_tsi_tb.sv
module pcm_tsi_tb;
  localparam int NS   = 8;
  localparam int SW   = 3;
  localparam int FB   = 8 * NS + 4;
  localparam int SKEW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic          bclk = 1'b0, fsx = 1'b0, fsr = 1'b0, dr = 1'b0;
  logic          delayed = 1'b0, loopback = 1'b0, pwr_up = 1'b0;
  logic [SW:0]   tx_cfg = '0, rx_cfg = '0;
  logic [7:0]    tx_byte = '0;
  logic [7:0]    rx_byte;
  logic          rx_valid, dx, dx_oe, tsx_n;

  pcm_tsi #(.NUM_SLOTS(NS), .SLOT_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .fsx_i(fsx), .fsr_i(fsr), .dr_i(dr),
    .delayed_i(delayed), .loopback_i(loopback), .pwr_up_i(pwr_up),
    .tx_cfg_i(tx_cfg), .rx_cfg_i(rx_cfg), .tx_byte_i(tx_byte),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .dx_o(dx), .dx_oe_o(dx_oe), .tsx_no(tsx_n)
  );

  int checks = 0, errors = 0;
  int ph = 7, txpos = 0, frame = 0, gate = 0;
  int tx_seen = 0, rx_seen = 0;
  string cur_req = "R1";
  logic [15:0] tx_q[$];
  logic [7:0]  rx_q[$];

  function automatic logic [7:0] pat(int k, int f);
    return 8'(k * 29 + f * 71 + 60);
  endfunction

  function automatic logic [7:0] txb(int f);
    return 8'(f * 53 + 17);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: pushes expected items, then plays the frames on the bus
  task automatic run_frames(int n);
    for (int f = 0; f < n; f++) begin
      int ts = delayed ? 1 + 8 * int'(tx_cfg[SW-1:0]) : 0;
      int rsl = delayed ? int'(rx_cfg[SW-1:0]) : 0;
      if (pwr_up) gate++;
      if (pwr_up && tx_cfg[SW] && gate >= 2)
        tx_q.push_back({8'(ts), loopback ? pat(rsl, frame) : txb(frame)});
      if (pwr_up && rx_cfg[SW]) rx_q.push_back(pat(rsl, frame));
      for (int b = 0; b < FB; b++) begin
        int rp = (b < SKEW) ? b - SKEW + FB : b - SKEW;
        int d = delayed ? rp - 1 : rp;
        logic [7:0] pv;
        pv = (d >= 0 && d < 8 * NS) ? pat(d / 8, frame) : 8'h00;
        @(negedge clk);
        bclk = 1'b1; ph = 0; txpos = b;
        fsx = (b == 0);
        fsr = (rp == 0);
        dr = (d >= 0 && d < 8 * NS) ? pv[7 - (d % 8)] : 1'b0;
        if (b == 0) tx_byte = txb(frame);
        else if (b == ts + 2) tx_byte = ~txb(frame);   // R12: corrupt after latch
        for (int p = 1; p < 8; p++) begin
          @(negedge clk);
          ph = p;
          if (p == 4) bclk = 1'b0;
        end
      end
      frame++;
    end
  endtask

  // monitor / scoreboard
  int col_n = 0, col_idx = 0, col_pos = 0;
  logic [7:0] col_b = '0;
  always @(posedge clk) begin
    #3;
    if (rst_ni) begin
      if (ph == 1) begin
        if (dx_oe) begin
          if (col_n == 0) col_pos = txpos;
          col_b = {col_b[6:0], dx};
          col_idx = col_n;
          col_n++;
          chk(tsx_n == 1'b0, "R6 tsx in high half", int'(tsx_n), 0);
          if (col_n == 8) begin
            col_n = 0;
            tx_seen++;
            if (tx_q.size() == 0) chk(1'b0, {"R1 unexpected tx byte ", cur_req}, int'(col_b), -1);
            else begin
              logic [15:0] e;
              e = tx_q.pop_front();
              chk({8'(col_pos), col_b} == e, {"R1 tx {pos,byte} ", cur_req},
                  int'({8'(col_pos), col_b}), int'(e));
            end
          end
        end else begin
          chk(tsx_n == 1'b1, "R6 tsx idle", int'(tsx_n), 1);
        end
      end else if (ph == 5) begin
        chk(tsx_n == !(dx_oe && col_idx != 7), "R6 tsx low half",
            int'(tsx_n), int'(!(dx_oe && col_idx != 7)));
      end
      if (rx_valid) begin
        rx_seen++;
        if (rx_q.size() == 0) chk(1'b0, {"R2 unexpected rx byte ", cur_req}, int'(rx_byte), -1);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          chk(rx_byte == e, {"R2 rx byte ", cur_req}, int'(rx_byte), int'(e));
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int t0, r0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(dx_oe == 1'b0, "R11 dx_oe", int'(dx_oe), 0);
    chk(tsx_n == 1'b1, "R11 tsx", int'(tsx_n), 1);
    chk(rx_valid == 1'b0, "R11 rx_valid", int'(rx_valid), 0);
    chk(rx_byte == 8'h00, "R11 rx_byte", int'(rx_byte), 0);

    // R7: powered down, configured, nothing happens
    cur_req = "R7"; delayed = 1'b1; tx_cfg = {1'b1, 3'd3}; rx_cfg = {1'b1, 3'd2};
    t0 = tx_seen; r0 = rx_seen;
    run_frames(1);
    chk(tx_seen == t0 && rx_seen == r0, "R7 power down quiet", tx_seen - t0 + rx_seen - r0, 0);

    // R8: first frame after power-up not driven, second is
    cur_req = "R8"; pwr_up = 1'b1; gate = 0; t0 = tx_seen;
    run_frames(1);
    chk(tx_seen == t0, "R8 first frame gated", tx_seen - t0, 0);
    run_frames(1);
    chk(tx_seen == t0 + 1, "R8 second frame drives", tx_seen - t0, 1);

    // R4: delayed mode, slot counters; R1 and R12 in every frame
    cur_req = "R4"; tx_cfg = {1'b1, 3'd5}; rx_cfg = {1'b1, 3'd0};
    run_frames(2);
    cur_req = "R4 last slot"; tx_cfg = {1'b1, 3'd7}; rx_cfg = {1'b1, 3'd7};
    run_frames(1);
    // R5: same slot, skewed frames
    cur_req = "R5"; tx_cfg = {1'b1, 3'd0}; rx_cfg = {1'b1, 3'd0};
    run_frames(1);
    // R12 labelled run
    cur_req = "R12"; tx_cfg = {1'b1, 3'd2}; rx_cfg = {1'b1, 3'd4};
    run_frames(1);

    // R3: non-delayed, slot number ignored
    cur_req = "R3"; delayed = 1'b0; tx_cfg = {1'b1, 3'd6}; rx_cfg = {1'b1, 3'd6};
    run_frames(2);

    // R9: loopback
    cur_req = "R9"; delayed = 1'b1; loopback = 1'b1;
    tx_cfg = {1'b1, 3'd5}; rx_cfg = {1'b1, 3'd1};
    run_frames(2);
    loopback = 1'b0;

    // R10: disabled directions
    cur_req = "R10"; tx_cfg = {1'b0, 3'd3}; rx_cfg = {1'b0, 3'd3};
    t0 = tx_seen; r0 = rx_seen;
    run_frames(1);
    chk(tx_seen == t0 && rx_seen == r0, "R10 both disabled", tx_seen - t0 + rx_seen - r0, 0);
    tx_cfg = {1'b1, 3'd3}; r0 = rx_seen;
    run_frames(1);
    chk(rx_seen == r0, "R10 rx disabled", rx_seen - r0, 0);

    // R7 / R8: power cycle restarts the gate
    cur_req = "R7"; pwr_up = 1'b0; gate = 0; rx_cfg = {1'b1, 3'd1};
    t0 = tx_seen; r0 = rx_seen;
    run_frames(1);
    chk(tx_seen == t0 && rx_seen == r0, "R7 power down again", tx_seen - t0 + rx_seen - r0, 0);
    cur_req = "R8"; pwr_up = 1'b1;
    run_frames(2);
    chk(tx_seen == t0 + 1, "R8 regated after power cycle", tx_seen - t0, 1);

    repeat (20) @(negedge clk);
    chk(tx_q.size() == 0, "R1 tx items outstanding", tx_q.size(), 0);
    chk(rx_q.size() == 0, "R2 rx items outstanding", rx_q.size(), 0);
    finish_run();
  end
endmodule